// File: doc/BRIEF.md
# Lane-Sequenced Vector Montgomery Multiplier

This unit multiplies two wide operands that are each split into unsigned 32-bit lanes (eight by default). It has two arithmetic modes. The plain mode keeps the low half of each lane product. The Montgomery mode forms `(c + ((c mod 2^32) * mu mod 2^32) * q) >> 32` per lane, with `c = a*b`. The constants `q` and `mu` come from the low two words of a modulus input. The conditional subtraction that would bring each lane into `[0, q)` is left to a later step, so Montgomery lanes may lie anywhere in `[0, 2q)`, truncated to 32 bits. A broadcast option pairs every lane of the first operand with one chosen lane of the second.

A pulse on `start_i` while the unit is idle captures the operands, the mode and the broadcast choice. The lanes are then processed a slot at a time, with `MULS` lane multipliers per slot. A plain slot takes one cycle. A Montgomery slot takes three cycles: product, reduction factor, fold. At the defaults this gives 4 and 12 busy cycles. Finished lanes collect in an accumulator register, which is cleared when an operation starts. The final vector goes to both `result_o` and the accumulator. Two hidden per-multiplier registers hold the full product and the reduction factor. They are zeroed at the end of every Montgomery slot. An external write or a wipe reaches the accumulator and both hidden registers.

Top module: `vec_mont_mul`

## Requirements
- R1: Once reset is released and before any stimulus, `busy_o` and `done_o` are 0 and `result_o` and `acc_o` are all zero.
- R2: With `mont_i`=0, lane i of the result (bits [32i+31:32i]) equals `(a_i * b_i) mod 2^32`.
- R3: With `mont_i`=1, lane i equals `((c + ((c mod 2^32) * mu mod 2^32) * q) >> 32) mod 2^32`, where `c = a_i*b_i`, `q = mod_i[31:0]` and `mu = mod_i[63:32]`. No final subtraction of `q` is made.
- R4: With `bcast_i`=1, every lane of operand A is paired with lane `bcast_lane_i` of operand B. Index 0 selects bits [31:0] and index 7 selects bits [255:224].
- R5: Suppose start is sampled at clock edge E0 while the unit is idle. `busy_o` is then high for exactly 4 cycles in plain mode, or 12 in Montgomery mode. `done_o` is high for the single cycle that follows, with `busy_o` low.
- R6: Operands, modulus, mode and broadcast choice are captured at the accepted start. A start request while `busy_o` is high is ignored, and input changes during the operation have no effect on the result.
- R7: When `done_o` is high, `result_o` and `acc_o` both hold the final vector. `acc_o` keeps that vector until the next start, write or wipe.
- R8: An accepted start clears the accumulator to zero in the first busy cycle.
- R9: `acc_we_i` loads `acc_wdata_i` into `acc_o` on the next cycle and also overwrites both hidden registers.
- R10: `wipe_i` zeroes the accumulator and both hidden registers on the next cycle and takes priority over `acc_we_i`.
- R11: Both hidden registers are zero in the cycle after each three-cycle Montgomery slot ends, unless a write is made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| mont_i | input | 1 | 1 selects Montgomery mode, 0 selects plain multiply |
| bcast_i | input | 1 | Broadcast one lane of operand B |
| bcast_lane_i | input | 3 | Index of the broadcast lane of operand B |
| opa_i | input | 256 | Operand A, eight 32-bit lanes |
| opb_i | input | 256 | Operand B, eight 32-bit lanes |
| mod_i | input | 64 | Low words of the modulus: q in [31:0], mu in [63:32] |
| acc_we_i | input | 1 | Overwrite accumulator and hidden registers |
| acc_wdata_i | input | 256 | Data for the overwrite |
| wipe_i | input | 1 | Zero accumulator and hidden registers |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 256 | Final lane vector |
| acc_o | output | 256 | Accumulator contents |

## Verification
The bench builds the block at its default parameters: 32-bit lanes, eight lanes and two multipliers. This gives four slots, so both the 4-cycle and the 12-cycle schedules are exercised, and slot boundaries fall between lanes 1/2, 3/4 and 5/6. The eight lanes make broadcast indices 0 and 7 reachable, which covers both ends of the operand. Montgomery moduli run from small odd primes up to values just below 2^32, which puts truncation of results above 2^32 within reach.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
   typedef enum logic [1:0] {
      PH_MUL  = 2'd0,
      PH_RED  = 2'd1,
      PH_FOLD = 2'd2
   } vmm_phase_e;

   localparam int unsigned MONT_STEPS = 3;
endpackage

// File: rtl/vmm_seq.sv
module vmm_seq
   import vmm_pkg::*;
#(
   parameter int unsigned SLOTS = 4,
   localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mont_i,
   output logic              launch_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              mont_o,
   output logic              write_o,
   output logic              last_o,
   output logic [SLOT_W-1:0] slot_o,
   output vmm_phase_e        phase_o
);
   logic              busy_q, done_q, mont_q;
   logic [SLOT_W-1:0] slot_q;
   vmm_phase_e        phase_q;

   assign launch_o = start_i && !busy_q;
   assign write_o  = busy_q && (!mont_q || phase_q == PH_FOLD);
   assign last_o   = write_o && (slot_q == SLOT_W'(SLOTS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         mont_q  <= 1'b0;
         slot_q  <= '0;
         phase_q <= PH_MUL;
      end else begin
         done_q <= 1'b0;
         if (launch_o) begin
            busy_q  <= 1'b1;
            mont_q  <= mont_i;
            slot_q  <= '0;
            phase_q <= PH_MUL;
         end else if (busy_q) begin
            if (last_o) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               phase_q <= PH_MUL;
            end else if (write_o) begin
               slot_q  <= slot_q + 1'b1;
               phase_q <= PH_MUL;
            end else begin
               unique case (phase_q)
                  PH_MUL:  phase_q <= PH_RED;
                  default: phase_q <= PH_FOLD;
               endcase
            end
         end
      end
   end

   assign busy_o  = busy_q;
   assign done_o  = done_q;
   assign mont_o  = mont_q;
   assign slot_o  = slot_q;
   assign phase_o = phase_q;
endmodule

// File: rtl/vmm_lane.sv
module vmm_lane
   import vmm_pkg::*;
#(
   parameter int unsigned LANE_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LANE_W-1:0]   a_i,
   input  logic [LANE_W-1:0]   b_i,
   input  logic [LANE_W-1:0]   q_i,
   input  logic [LANE_W-1:0]   mu_i,
   input  logic                mont_i,
   input  logic                act_i,
   input  vmm_phase_e          phase_i,
   input  logic                wipe_i,
   input  logic                load_i,
   input  logic [2*LANE_W-1:0] ld_prod_i,
   input  logic [LANE_W-1:0]   ld_red_i,
   output logic [LANE_W-1:0]   res_o,
   output logic [2*LANE_W-1:0] prod_o,
   output logic [LANE_W-1:0]   red_o
);
   logic [2*LANE_W-1:0] prod_q, full;
   logic [LANE_W-1:0]   red_q, red_nxt;
   logic [2*LANE_W:0]   fold;

   assign full    = (2*LANE_W)'(a_i) * (2*LANE_W)'(b_i);
   assign red_nxt = prod_q[LANE_W-1:0] * mu_i;
   assign fold    = (2*LANE_W+1)'(prod_q) + (2*LANE_W+1)'(red_q) * (2*LANE_W+1)'(q_i);
   assign res_o   = mont_i ? LANE_W'(fold >> LANE_W) : full[LANE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
         red_q  <= '0;
      end else if (wipe_i) begin
         prod_q <= '0;
         red_q  <= '0;
      end else if (load_i) begin
         prod_q <= ld_prod_i;
         red_q  <= ld_red_i;
      end else if (act_i && mont_i) begin
         unique case (phase_i)
            PH_MUL:  prod_q <= full;
            PH_RED:  red_q  <= red_nxt;
            default: begin
               prod_q <= '0;
               red_q  <= '0;
            end
         endcase
      end
   end

   assign prod_o = prod_q;
   assign red_o  = red_q;
endmodule

// File: rtl/vec_mont_mul.sv
module vec_mont_mul
   import vmm_pkg::*;
#(
   parameter int unsigned LANE_W = 32,
   parameter int unsigned LANES  = 8,
   parameter int unsigned MULS   = 2,
   localparam int unsigned VEC_W  = LANE_W * LANES,
   localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               mont_i,
   input  logic               bcast_i,
   input  logic [IDX_W-1:0]   bcast_lane_i,
   input  logic [VEC_W-1:0]   opa_i,
   input  logic [VEC_W-1:0]   opb_i,
   input  logic [2*LANE_W-1:0] mod_i,
   input  logic               acc_we_i,
   input  logic [VEC_W-1:0]   acc_wdata_i,
   input  logic               wipe_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [VEC_W-1:0]   result_o,
   output logic [VEC_W-1:0]   acc_o
);
   localparam int unsigned SLOTS  = LANES / MULS;
   localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   if (MULS == 0 || LANES % MULS != 0) begin : g_bad_muls
      $error("MULS must divide LANES");
   end
   if (LANES != (1 << IDX_W)) begin : g_bad_lanes
      $error("LANES must be a power of two");
   end
   if (LANE_W < 2) begin : g_bad_width
      $error("LANE_W too small");
   end

   logic               launch, write, last, mont_q;
   logic [SLOT_W-1:0]  slot;
   vmm_phase_e         phase;

   logic [VEC_W-1:0]   opa_q, opb_q, acc_q, acc_nxt, res_q;
   logic [LANE_W-1:0]  q_q, mu_q;
   logic               bc_q;
   logic [IDX_W-1:0]   bl_q;

   logic [LANE_W-1:0]        slot_res  [MULS];
   logic [MULS*2*LANE_W-1:0] hid_prod_flat;
   logic [MULS*LANE_W-1:0]   hid_red_flat;

   vmm_seq #(.SLOTS(SLOTS)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .mont_i  (mont_i),
      .launch_o(launch),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .mont_o  (mont_q),
      .write_o (write),
      .last_o  (last),
      .slot_o  (slot),
      .phase_o (phase)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opa_q <= '0;
         opb_q <= '0;
         q_q   <= '0;
         mu_q  <= '0;
         bc_q  <= 1'b0;
         bl_q  <= '0;
      end else if (launch) begin
         opa_q <= opa_i;
         opb_q <= opb_i;
         q_q   <= mod_i[LANE_W-1:0];
         mu_q  <= mod_i[2*LANE_W-1:LANE_W];
         bc_q  <= bcast_i;
         bl_q  <= bcast_lane_i;
      end
   end

   for (genvar k = 0; k < MULS; k++) begin : g_mul
      localparam int unsigned PLO = (2 * k) % LANES;
      localparam int unsigned PHI = (2 * k + 1) % LANES;
      localparam int unsigned RSL = (k + LANES / 2) % LANES;
      logic [IDX_W-1:0]  lidx;
      logic [LANE_W-1:0] a_k, b_k;

      assign lidx = IDX_W'(int'(slot) * MULS + k);
      assign a_k  = opa_q[lidx*LANE_W +: LANE_W];
      assign b_k  = bc_q ? opb_q[bl_q*LANE_W +: LANE_W] : opb_q[lidx*LANE_W +: LANE_W];

      vmm_lane #(.LANE_W(LANE_W)) i_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .a_i      (a_k),
         .b_i      (b_k),
         .q_i      (q_q),
         .mu_i     (mu_q),
         .mont_i   (mont_q),
         .act_i    (busy_o),
         .phase_i  (phase),
         .wipe_i   (wipe_i),
         .load_i   (acc_we_i),
         .ld_prod_i({acc_wdata_i[PHI*LANE_W +: LANE_W], acc_wdata_i[PLO*LANE_W +: LANE_W]}),
         .ld_red_i (acc_wdata_i[RSL*LANE_W +: LANE_W]),
         .res_o    (slot_res[k]),
         .prod_o   (hid_prod_flat[k*2*LANE_W +: 2*LANE_W]),
         .red_o    (hid_red_flat[k*LANE_W +: LANE_W])
      );
   end

   always_comb begin
      acc_nxt = acc_q;
      if (launch) begin
         acc_nxt = '0;
      end else if (write) begin
         for (int k = 0; k < MULS; k++) begin
            acc_nxt[(int'(slot) * MULS + k) * LANE_W +: LANE_W] = slot_res[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         res_q <= '0;
      end else begin
         if (wipe_i)        acc_q <= '0;
         else if (acc_we_i) acc_q <= acc_wdata_i;
         else               acc_q <= acc_nxt;
         if (last) res_q <= acc_nxt;
      end
   end

   assign acc_o    = acc_q;
   assign result_o = res_q;
endmodule

// File: rtl/vmm_chk.sv
module vmm_chk
   import vmm_pkg::*;
#(
   parameter int unsigned LANE_W = 32,
   parameter int unsigned LANES  = 8,
   parameter int unsigned MULS   = 2,
   localparam int unsigned VEC_W = LANE_W * LANES
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_i,
   input logic                     acc_we_i,
   input logic                     wipe_i,
   input logic [VEC_W-1:0]         acc_wdata_i,
   input logic                     busy_o,
   input logic                     done_o,
   input logic [VEC_W-1:0]         result_o,
   input logic [VEC_W-1:0]         acc_o,
   input logic                     mont_q,
   input vmm_phase_e               phase,
   input logic [MULS*2*LANE_W-1:0] hid_prod_flat,
   input logic [MULS*LANE_W-1:0]   hid_red_flat
);
   localparam int unsigned SLOTS = LANES / MULS;
   localparam int unsigned CNT_W = $clog2(SLOTS * MONT_STEPS + 2);

   logic [CNT_W-1:0] busy_cnt;
   logic             hid_zero;

   assign hid_zero = (hid_prod_flat == '0) && (hid_red_flat == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  busy_cnt <= '0;
      else if (start_i && !busy_o) busy_cnt <= '0;
      else if (busy_o)             busy_cnt <= busy_cnt + 1'b1;
   end

   // R5 R6
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_cnt == (mont_q ? CNT_W'(SLOTS * MONT_STEPS) : CNT_W'(SLOTS)));

   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !acc_we_i && !wipe_i) |=> (busy_o && acc_o == '0));

   // R9
   acc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_we_i && !wipe_i) |=> acc_o == $past(acc_wdata_i));

   // R10
   wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wipe_i |=> (acc_o == '0 && hid_zero));

   // R7
   result_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(!acc_we_i && !wipe_i)) |-> result_o == acc_o);

   // R7
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i && !acc_we_i && !wipe_i) |=> $stable(acc_o));

   // R11
   hid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && mont_q && phase == PH_FOLD && !acc_we_i && !wipe_i) |=> hid_zero);
endmodule

bind vec_mont_mul vmm_chk #(.LANE_W(LANE_W), .LANES(LANES), .MULS(MULS)) i_vmm_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .acc_we_i     (acc_we_i),
   .wipe_i       (wipe_i),
   .acc_wdata_i  (acc_wdata_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .result_o     (result_o),
   .acc_o        (acc_o),
   .mont_q       (mont_q),
   .phase        (phase),
   .hid_prod_flat(hid_prod_flat),
   .hid_red_flat (hid_red_flat)
);

// File: tb/test_vec_mont_mul.sv
module test_vec_mont_mul;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic [31:0] sa;
      logic [31:0] sb;
      logic [31:0] q;
      logic        mont;
      logic        bc;
      logic [2:0]  lane;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0,          1'b0, 1'b0, 3'd0},
      '{32'h1234_5678, 32'h9ABC_DEF0, 32'd0,          1'b0, 1'b0, 3'd0},
      '{32'h0BAD_F00D, 32'h7777_3333, 32'd0,          1'b0, 1'b1, 3'd0},
      '{32'hCAFE_0001, 32'h0F0F_1234, 32'd0,          1'b0, 1'b1, 3'd7},
      '{32'h0000_1357, 32'h0000_2468, 32'd3329,       1'b1, 1'b0, 3'd0},
      '{32'h00AB_CDEF, 32'h0012_3457, 32'd8380417,    1'b1, 1'b0, 3'd0},
      '{32'hDEAD_BEEF, 32'h1357_9BDF, 32'hFFFF_FFFB,  1'b1, 1'b1, 3'd3},
      '{32'h7654_3210, 32'hFEDC_BA98, 32'h7FFF_FFFF,  1'b1, 1'b0, 3'd0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0, mont_i = 1'b0, bcast_i = 1'b0;
   logic [2:0]   bcast_lane_i = '0;
   logic [255:0] opa_i = '0, opb_i = '0, acc_wdata_i = '0;
   logic [63:0]  mod_i = '0;
   logic         acc_we_i = 1'b0, wipe_i = 1'b0;
   logic         busy_o, done_o;
   logic [255:0] result_o, acc_o;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   vec_mont_mul i_vec_mont_mul (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mont_i(mont_i),
      .bcast_i(bcast_i), .bcast_lane_i(bcast_lane_i), .opa_i(opa_i), .opb_i(opb_i),
      .mod_i(mod_i), .acc_we_i(acc_we_i), .acc_wdata_i(acc_wdata_i), .wipe_i(wipe_i),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .acc_o(acc_o)
   );

   function automatic logic [31:0] mu_of(input logic [31:0] q);
      logic [31:0] x;
      x = q;
      for (int i = 0; i < 5; i++) x = x * (32'd2 - q * x);
      return -x;
   endfunction

   function automatic logic [255:0] lanes_of(input logic [31:0] seed, input logic [31:0] q,
                                             input logic mont);
      logic [255:0] v;
      logic [31:0]  e;
      for (int i = 0; i < 8; i++) begin
         e = seed * (2 * i + 3) + i * 32'h0101_0101;
         if (mont && q != 0) e = e % q;
         v[i*32 +: 32] = e;
      end
      return v;
   endfunction

   function automatic logic [255:0] expect_vec(input logic [255:0] a, input logic [255:0] b,
                                               input logic [31:0] q, input logic [31:0] mu,
                                               input logic mont, input logic bc,
                                               input logic [2:0] lane);
      logic [255:0] v;
      logic [31:0]  ai, bi, m;
      logic [63:0]  c;
      logic [64:0]  s;
      for (int i = 0; i < 8; i++) begin
         ai = a[i*32 +: 32];
         bi = bc ? b[lane*32 +: 32] : b[i*32 +: 32];
         c  = 64'(ai) * 64'(bi);
         if (mont) begin
            m = c[31:0] * mu;
            s = 65'(c) + 65'(m) * 65'(q);
            v[i*32 +: 32] = s[63:32];
         end else begin
            v[i*32 +: 32] = c[31:0];
         end
      end
      return v;
   endfunction

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [255:0] a, input logic [255:0] b, input logic [63:0] md,
                         input logic mont, input logic bc, input logic [2:0] lane,
                         input logic poke, output logic [255:0] res, output int n);
      @(negedge clk);
      opa_i = a; opb_i = b; mod_i = md; mont_i = mont; bcast_i = bc; bcast_lane_i = lane;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R8 accumulator cleared at start", acc_o, '0);
      n = 0;
      while (!done_o && n < 64) begin
         if (busy_o) n++;
         if (poke && n == 3) begin
            start_i = 1'b1; mont_i = !mont; opa_i = ~a; opb_i = a; mod_i = ~md;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      res = result_o;
      chk("R7 accumulator equals result at done", acc_o, res);
      @(negedge clk);
      chk("R5 done is a single-cycle pulse", 256'(done_o), 256'd0);
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [255:0] a, b, r, e;
      logic [31:0]  mu;
      int           n;
      string        tag;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy after reset", 256'(busy_o), 256'd0);
      chk("R1 done after reset", 256'(done_o), 256'd0);
      chk("R1 result after reset", result_o, '0);
      chk("R1 accumulator after reset", acc_o, '0);

      // R2 R3 R4 R5: vector table; Montgomery rows also cover every slot (R11)
      for (int v = 0; v < 8; v++) begin
         a  = lanes_of(VECS[v].sa, VECS[v].q, VECS[v].mont);
         b  = lanes_of(VECS[v].sb, VECS[v].q, VECS[v].mont);
         mu = mu_of(VECS[v].q);
         e  = expect_vec(a, b, VECS[v].q, mu, VECS[v].mont, VECS[v].bc, VECS[v].lane);
         run_op(a, b, {mu, VECS[v].q}, VECS[v].mont, VECS[v].bc, VECS[v].lane, 1'b0, r, n);
         tag = VECS[v].bc ? "R4 broadcast result" : (VECS[v].mont ? "R3 R11 Montgomery result"
                                                                    : "R2 plain result");
         chk(tag, r, e);
         chk("R5 busy cycle count", 256'(n), VECS[v].mont ? 256'd12 : 256'd4);
         repeat (3) @(negedge clk);
         chk("R7 accumulator kept after done", acc_o, e);
      end

      // R6 start while busy ignored, input changes ignored
      a  = lanes_of(32'h2468_ACE1, 32'd3329, 1'b1);
      b  = lanes_of(32'h1111_2223, 32'd3329, 1'b1);
      mu = mu_of(32'd3329);
      e  = expect_vec(a, b, 32'd3329, mu, 1'b1, 1'b0, 3'd0);
      run_op(a, b, {mu, 32'd3329}, 1'b1, 1'b0, 3'd0, 1'b1, r, n);
      chk("R6 result with start during busy", r, e);
      chk("R6 busy cycle count unaffected", 256'(n), 256'd12);
      a = lanes_of(32'h0000_F00F, 32'd0, 1'b0);
      e = expect_vec(a, a, 32'd0, 32'd0, 1'b0, 1'b0, 3'd0);
      run_op(a, a, 64'd0, 1'b0, 1'b0, 3'd0, 1'b1, r, n);
      chk("R6 plain result with start during busy", r, e);
      chk("R6 plain busy cycle count", 256'(n), 256'd4);

      // R9 external accumulator write
      @(negedge clk);
      acc_we_i = 1'b1; acc_wdata_i = {8{32'hA5A5_5A5A}};
      @(negedge clk);
      acc_we_i = 1'b0;
      chk("R9 accumulator write", acc_o, {8{32'hA5A5_5A5A}});

      // R10 wipe has priority over write
      wipe_i = 1'b1; acc_we_i = 1'b1; acc_wdata_i = {8{32'h1234_0FED}};
      @(negedge clk);
      wipe_i = 1'b0; acc_we_i = 1'b0;
      chk("R10 wipe clears accumulator", acc_o, '0);
      @(negedge clk);
      chk("R10 accumulator stays cleared", acc_o, '0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule